// File: doc/BRIEF.md
# Display matrix window tracker

This block follows the raster beam of a character-based video generator and reports whether the beam is over the character matrix. It takes the horizontal and vertical beam counters and the programmed placement of the matrix: top line, left column, column count, row count and a cell-height select. From these it drives the enables that gate the horizontal cell counter, the video matrix address counter and the cell depth counter.

Three set/reset registers form a chain. The row-span register arms when the vertical counter reaches the top line. The window register needs the row-span register to be set before the horizontal counter can open it at the left column. The frame register latches on the first window entry of a frame and holds until the last matrix line has passed. An early bus-available indication comes from the next state of the window register, so it leads the in-matrix flag by one cycle.

Top module: `mxw_tracker`

## Requirements
- R1: While rst_ni is low, matrix_line_n_o and in_matrix_n_o are 1, frame_active_o is 0 and bus_avail_o is 1. Reset acts without waiting for a clock edge.
- R2: matrix_line_n_o goes to 0 in the cycle after a clock edge at which vpos_i equals top_line_i.
- R3: in_matrix_n_o goes to 0 after an edge at which hpos_i equals left_col_i while matrix_line_n_o is already 0. When matrix_line_n_o is 1, hpos_i reaching left_col_i has no effect.
- R4: in_matrix_n_o returns to 1 after an edge at which hpos_i equals left_col_i + num_cols_i * 2^CELL_W_LOG.
- R5: matrix_line_n_o returns to 1 after an edge at which vpos_i equals top_line_i + num_rows_i * H. H is 2^CELL_H_LOG when tall_cells_i is 0 and twice that when it is 1.
- R6: frame_active_o rises only on a window entry, which is the R3 condition. It then stays 1 across lines and positions outside the horizontal window until the R5 end line or a frame start.
- R7: A frame_start_i pulse clears all three registers at the next edge: matrix_line_n_o and in_matrix_n_o go to 1 and frame_active_o goes to 0.
- R8: When a set condition and a clear condition meet at the same edge, the set wins. This includes a frame start at the top line or at a window entry.
- R9: bus_avail_o equals the value that in_matrix_n_o takes after the next edge. It therefore falls and rises exactly one cycle before in_matrix_n_o does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle frame start strobe |
| hpos_i | input | HPOS_W | Horizontal beam counter |
| vpos_i | input | VPOS_W | Vertical beam counter |
| top_line_i | input | VPOS_W | First matrix line |
| left_col_i | input | HPOS_W | Left matrix column |
| num_cols_i | input | COLS_W | Matrix width in cells |
| num_rows_i | input | ROWS_W | Matrix height in cells |
| tall_cells_i | input | 1 | Selects double cell height |
| matrix_line_n_o | output | 1 | Low while within the matrix row span |
| in_matrix_n_o | output | 1 | Low while the beam is inside the matrix |
| frame_active_o | output | 1 | High from first entry until after the last matrix line |
| bus_avail_o | output | 1 | Early copy of in_matrix_n_o, leading by one cycle |

## Verification
The bench uses the default widths: 9-bit beam counters, 8-pixel cells and 8- or 16-line cells. Most of the table runs on a 2-column, 1-row matrix at line 10, column 20, which places the window end at column 36 and the row end at line 18. These values keep every boundary within a few vectors. Line 300 checks that no window opens outside the row span. The table drives frame start against the set conditions to reach set priority. A directed pass with tall cells moves the row end to line 26.

// File: rtl/mxw_pkg.sv
package mxw_pkg;
  localparam int unsigned LATCH_N = 3;
  localparam int unsigned L_ROW   = 0;  // row span, armed by top line
  localparam int unsigned L_WIN   = 1;  // horizontal window
  localparam int unsigned L_FRM   = 2;  // per-frame activity

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mxw_sr_latch.sv
module mxw_sr_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic d_o
);
  // set dominates clear
  assign d_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_o;
  end
endmodule

// File: rtl/mxw_bounds.sv
module mxw_bounds #(
  parameter int unsigned HPOS_W     = 9,
  parameter int unsigned VPOS_W     = 9,
  parameter int unsigned COLS_W     = 7,
  parameter int unsigned ROWS_W     = 6,
  parameter int unsigned CELL_W_LOG = 3,
  parameter int unsigned CELL_H_LOG = 3,
  localparam int unsigned H_END_W = mxw_pkg::max_u(HPOS_W, COLS_W + CELL_W_LOG) + 1,
  localparam int unsigned V_END_W = mxw_pkg::max_u(VPOS_W, ROWS_W + CELL_H_LOG + 1) + 1
) (
  input  logic [HPOS_W-1:0]  left_col_i,
  input  logic [VPOS_W-1:0]  top_line_i,
  input  logic [COLS_W-1:0]  num_cols_i,
  input  logic [ROWS_W-1:0]  num_rows_i,
  input  logic               tall_cells_i,
  output logic [H_END_W-1:0] h_end_o,
  output logic [V_END_W-1:0] v_end_o
);
  logic [H_END_W-1:0] h_span;
  logic [V_END_W-1:0] v_span;

  assign h_span = H_END_W'(num_cols_i) << CELL_W_LOG;
  assign v_span = tall_cells_i ? (V_END_W'(num_rows_i) << (CELL_H_LOG + 1))
                               : (V_END_W'(num_rows_i) << CELL_H_LOG);

  assign h_end_o = H_END_W'(left_col_i) + h_span;
  assign v_end_o = V_END_W'(top_line_i) + v_span;
endmodule

// File: rtl/mxw_tracker.sv
module mxw_tracker #(
  parameter int unsigned HPOS_W     = 9,
  parameter int unsigned VPOS_W     = 9,
  parameter int unsigned COLS_W     = 7,
  parameter int unsigned ROWS_W     = 6,
  parameter int unsigned CELL_W_LOG = 3,
  parameter int unsigned CELL_H_LOG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic [VPOS_W-1:0] vpos_i,
  input  logic [VPOS_W-1:0] top_line_i,
  input  logic [HPOS_W-1:0] left_col_i,
  input  logic [COLS_W-1:0] num_cols_i,
  input  logic [ROWS_W-1:0] num_rows_i,
  input  logic              tall_cells_i,
  output logic              matrix_line_n_o,
  output logic              in_matrix_n_o,
  output logic              frame_active_o,
  output logic              bus_avail_o
);
  import mxw_pkg::*;

  localparam int unsigned H_END_W = max_u(HPOS_W, COLS_W + CELL_W_LOG) + 1;
  localparam int unsigned V_END_W = max_u(VPOS_W, ROWS_W + CELL_H_LOG + 1) + 1;

  logic [H_END_W-1:0] h_end;
  logic [V_END_W-1:0] v_end;
  logic               hit_top, hit_left, hit_h_end, hit_v_end, entry;
  logic [LATCH_N-1:0] set_v, clr_v, q_v, d_v;

  mxw_bounds #(
    .HPOS_W(HPOS_W), .VPOS_W(VPOS_W), .COLS_W(COLS_W), .ROWS_W(ROWS_W),
    .CELL_W_LOG(CELL_W_LOG), .CELL_H_LOG(CELL_H_LOG)
  ) i_bounds (
    .left_col_i  (left_col_i),
    .top_line_i  (top_line_i),
    .num_cols_i  (num_cols_i),
    .num_rows_i  (num_rows_i),
    .tall_cells_i(tall_cells_i),
    .h_end_o     (h_end),
    .v_end_o     (v_end)
  );

  assign hit_top   = (vpos_i == top_line_i);
  assign hit_left  = (hpos_i == left_col_i);
  assign hit_h_end = (H_END_W'(hpos_i) == h_end);
  assign hit_v_end = (V_END_W'(vpos_i) == v_end);
  assign entry     = q_v[L_ROW] & hit_left;

  always_comb begin
    set_v        = '0;
    clr_v        = '0;
    set_v[L_ROW] = hit_top;
    clr_v[L_ROW] = hit_v_end | frame_start_i;
    set_v[L_WIN] = entry;
    clr_v[L_WIN] = hit_h_end | frame_start_i;
    set_v[L_FRM] = entry;
    clr_v[L_FRM] = hit_v_end | frame_start_i;
  end

  for (genvar g = 0; g < LATCH_N; g++) begin : g_latch
    mxw_sr_latch i_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (q_v[g]),
      .d_o   (d_v[g])
    );
  end

  assign matrix_line_n_o = ~q_v[L_ROW];
  assign in_matrix_n_o   = ~q_v[L_WIN];
  assign frame_active_o  = q_v[L_FRM];
  // next-state of the window register, one cycle ahead of in_matrix_n_o
  assign bus_avail_o     = ~d_v[L_WIN];
endmodule

// File: rtl/mxw_tracker_chk.sv
module mxw_tracker_chk #(
  parameter int unsigned HPOS_W     = 9,
  parameter int unsigned VPOS_W     = 9,
  parameter int unsigned COLS_W     = 7,
  parameter int unsigned ROWS_W     = 6,
  parameter int unsigned CELL_W_LOG = 3,
  parameter int unsigned CELL_H_LOG = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic [HPOS_W-1:0] hpos_i,
  input logic [VPOS_W-1:0] vpos_i,
  input logic [VPOS_W-1:0] top_line_i,
  input logic [HPOS_W-1:0] left_col_i,
  input logic [COLS_W-1:0] num_cols_i,
  input logic [ROWS_W-1:0] num_rows_i,
  input logic              tall_cells_i,
  input logic              matrix_line_n_o,
  input logic              in_matrix_n_o,
  input logic              frame_active_o,
  input logic              bus_avail_o
);
  int   win_end;
  logic at_left, at_top, armed;

  assign win_end = int'(left_col_i) + int'(num_cols_i) * (1 << CELL_W_LOG);
  assign at_left = (hpos_i == left_col_i);
  assign at_top  = (vpos_i == top_line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (matrix_line_n_o && in_matrix_n_o && !frame_active_o);
    end
  end

  // R2
  row_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_top |=> !matrix_line_n_o);

  // R3
  entry_needs_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_matrix_n_o) |-> $past(!matrix_line_n_o && at_left));

  // R4
  win_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(hpos_i) == win_end && !at_left && !frame_start_i) |=> in_matrix_n_o);

  // R6
  frame_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_active_o) |-> $past(at_left && !matrix_line_n_o));

  // R7
  frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !at_top && !at_left) |=>
      (matrix_line_n_o && in_matrix_n_o && !frame_active_o));

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && at_top) |=> !matrix_line_n_o);

  // R9
  bus_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> (in_matrix_n_o == $past(bus_avail_o)));
endmodule

bind mxw_tracker mxw_tracker_chk #(
  .HPOS_W(HPOS_W), .VPOS_W(VPOS_W), .COLS_W(COLS_W), .ROWS_W(ROWS_W),
  .CELL_W_LOG(CELL_W_LOG), .CELL_H_LOG(CELL_H_LOG)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_start_i  (frame_start_i),
  .hpos_i         (hpos_i),
  .vpos_i         (vpos_i),
  .top_line_i     (top_line_i),
  .left_col_i     (left_col_i),
  .num_cols_i     (num_cols_i),
  .num_rows_i     (num_rows_i),
  .tall_cells_i   (tall_cells_i),
  .matrix_line_n_o(matrix_line_n_o),
  .in_matrix_n_o  (in_matrix_n_o),
  .frame_active_o (frame_active_o),
  .bus_avail_o    (bus_avail_o)
);

// File: tb/test_mxw_tracker.sv
module test_mxw_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_start_i = 1'b0;
  logic [8:0] hpos_i = '0;
  logic [8:0] vpos_i = '0;
  logic [8:0] top_line_i = 9'd10;
  logic [8:0] left_col_i = 9'd20;
  logic [6:0] num_cols_i = 7'd2;
  logic [5:0] num_rows_i = 6'd1;
  logic       tall_cells_i = 1'b0;
  logic       matrix_line_n_o, in_matrix_n_o, frame_active_o, bus_avail_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #5 clk_i = ~clk_i;

  mxw_tracker i_mxw_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .hpos_i(hpos_i), .vpos_i(vpos_i), .top_line_i(top_line_i),
    .left_col_i(left_col_i), .num_cols_i(num_cols_i), .num_rows_i(num_rows_i),
    .tall_cells_i(tall_cells_i), .matrix_line_n_o(matrix_line_n_o),
    .in_matrix_n_o(in_matrix_n_o), .frame_active_o(frame_active_o),
    .bus_avail_o(bus_avail_o)
  );

  // {vpos, hpos, frame_start, exp bus (before edge), exp line_n, exp in_n, exp frame (after edge)}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {9'd5,   9'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R2 idle
    {9'd10,  9'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 arm
    {9'd10,  9'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 R6 R9 entry
    {9'd10,  9'd21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 hold
    {9'd10,  9'd36, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 R9 close
    {9'd11,  9'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 second line
    {9'd11,  9'd36, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 R6
    {9'd18,  9'd5,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 R6 end line
    {9'd18,  9'd20, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 no entry
    {9'd300, 9'd20, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 far line
    {9'd10,  9'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 rearm
    {9'd10,  9'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 entry
    {9'd12,  9'd25, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 frame start
    {9'd10,  9'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 top vs start
    {9'd10,  9'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}   // R8 entry vs start
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic step(input int v, input int h, input logic fs);
    @(negedge clk_i);
    vpos_i = 9'(v);
    hpos_i = 9'(h);
    frame_start_i = fs;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 line_n", matrix_line_n_o, 1'b1);
    chk("R1 in_n",   in_matrix_n_o,   1'b1);
    chk("R1 frame",  frame_active_o,  1'b0);
    chk("R1 bus",    bus_avail_o,     1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      vpos_i        = VEC[i][22:14];
      hpos_i        = VEC[i][13:5];
      frame_start_i = VEC[i][4];
      #1;
      chk($sformatf("R9 bus v%0d", i), bus_avail_o, VEC[i][3]);
      @(posedge clk_i);
      #1;
      chk($sformatf("R2/R5 line_n v%0d", i), matrix_line_n_o, VEC[i][2]);
      chk($sformatf("R3/R4 in_n v%0d", i),   in_matrix_n_o,   VEC[i][1]);
      chk($sformatf("R6 frame v%0d", i),     frame_active_o,  VEC[i][0]);
    end

    // R1: asynchronous reset mid-window
    @(negedge clk_i);
    frame_start_i = 1'b0;
    hpos_i = 9'd22;
    rst_ni = 1'b0;
    #1;
    chk("R1 async line_n", matrix_line_n_o, 1'b1);
    chk("R1 async in_n",   in_matrix_n_o,   1'b1);
    chk("R1 async frame",  frame_active_o,  1'b0);

    // R5: tall cells double the row span (end at line 26)
    tall_cells_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(10, 0, 1'b0);
    chk("R5 tall arm", matrix_line_n_o, 1'b0);
    step(18, 0, 1'b0);
    chk("R5 tall line 18 held", matrix_line_n_o, 1'b0);
    step(25, 0, 1'b0);
    chk("R5 tall line 25 held", matrix_line_n_o, 1'b0);
    step(26, 0, 1'b0);
    chk("R5 tall end", matrix_line_n_o, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule